// File: doc/BRIEF.md
# I2S Slave Audio Receiver

This block receives serial audio as the slave end of an I2S link. An external master drives the bit clock, the word-select line and the serial data. The block brings all three lines into the system clock domain through two-flop synchronisers and finds bit-clock rising edges in that domain. It then shifts in data MSB first and cuts the stream into fixed 16-bit packets. The data length and the channel length do not change the packet size. A 32-bit channel therefore arrives as two packets in a row, upper half first, and the host puts the halves back together.

Each finished packet goes into a receive buffer together with the channel side it belongs to. The host sees a buffer-full flag, an overrun flag and one combined interrupt line, and it reads through two strobes: one for the data register and one for the status register. Reception is framed by an enumerated state machine:

- `ST_IDLE`: reception is off.
- `ST_ALIGN`: the block is enabled and waits for a word-select transition, so that it never starts in the middle of a word.
- `ST_RECV`: packets are being collected.
- `ST_FINISH`: the enable has dropped and the word in progress is being completed.

The state machine takes these transitions:

- `ST_IDLE` to `ST_ALIGN`: the enable goes high.
- `ST_ALIGN` to `ST_IDLE`: the enable goes low.
- `ST_ALIGN` to `ST_RECV`: a word-select change is seen.
- `ST_RECV` to `ST_FINISH`: the enable goes low.
- `ST_RECV` to `ST_IDLE`: the enable is low and the word ends in the same cycle.
- `ST_FINISH` to `ST_RECV`: the enable comes back.
- `ST_FINISH` to `ST_IDLE`: the word ends.

Top module: `i2s_rx_slave`

## Requirements
- R1: Serial data is sampled on rising bit-clock edges, MSB first. The first bit after the rising edge that carries a word-select change is the MSB of the new word, and each 16 sampled bits form one packet.
- R2: A 32-bit channel slot yields two packets in a row. The first holds bits 31..16 and the second holds bits 15..0, and both carry the same channel side.
- R3: `rx_full` goes to 1 when a packet enters the buffer. A one-cycle `rd_data` pulse clears it.
- R4: `rx_side` gives the word-select level seen during the packet's MSB, with 0 for the left channel and 1 for the right channel. It is updated with every packet loaded into the buffer.
- R5: If a packet completes while `rx_full` is 1 and no `rd_data` pulse arrives in that cycle, `rx_ovr` goes to 1. The new packet is discarded and `rx_data` and `rx_side` keep the older packet.
- R6: `rx_ovr` clears only after a `rd_data` pulse is followed by a `rd_stat` pulse. A `rd_stat` pulse on its own leaves it set.
- R7: `irq` equals (`rx_full` AND `full_ie`) OR (`rx_ovr` AND `err_ie`).
- R8: After `enable` rises, bits up to and including the next word-select change edge are discarded. Reception starts with the word that follows.
- R9: If `enable` falls during a word, that word is still completed and all of its packets are delivered. The word that follows is not received.
- R10: While the block is idle, bit-clock activity produces no packet.
- R11: After reset, `rx_full`, `rx_ovr` and `irq` are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Reception enable |
| full_ie | input | 1 | Interrupt enable for buffer full |
| err_ie | input | 1 | Interrupt enable for overrun |
| rd_data | input | 1 | One-cycle strobe: host reads the data register |
| rd_stat | input | 1 | One-cycle strobe: host reads the status register |
| sck | input | 1 | Bit clock from the external master |
| ws | input | 1 | Word select from the external master |
| sd | input | 1 | Serial data |
| rx_data | output | 16 | Receive buffer contents |
| rx_side | output | 1 | Channel side of the buffered packet (0 left, 1 right) |
| rx_full | output | 1 | Receive buffer holds an unread packet |
| rx_ovr | output | 1 | Overrun flag |
| irq | output | 1 | Combined interrupt |

## Verification
A bit-clock rising edge at the pins reaches the buffer four system clocks later:

- two clocks pass in the synchroniser,
- one clock in the framer's packet pulse,
- one clock in the buffer register.

`rx_full`, `rx_data`, `rx_side` and `rx_ovr` are therefore due four clocks after the edge that carries a packet's last bit. `irq` follows in the same cycle, and the host strobes take effect one clock after they are driven. The bench holds each bit-clock half period for four system clocks and waits two more clocks after the final rising edge before it samples. It drives and samples on falling system-clock edges, so every check falls well after the due cycle and before the next packet can arrive.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

    localparam int PKT_BITS    = 16;
    localparam int SYNC_DEPTH  = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ALIGN  = 2'd1,
        ST_RECV   = 2'd2,
        ST_FINISH = 2'd3
    } rx_state_e;

endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[b]};
            end
        end

        assign sync_out[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/i2s_rx_frame.sv
module i2s_rx_frame
    import i2s_rx_pkg::*;
#(
    parameter int PKT_W = PKT_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sck_s,
    input  logic             ws_s,
    input  logic             sd_s,
    output logic             pkt_valid,
    output logic [PKT_W-1:0] pkt_data,
    output logic             pkt_side
);

    localparam int               CNT_W = $clog2(PKT_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(PKT_W - 1);

    rx_state_e        state_q, state_d;
    logic             sck_d;
    logic             ws_prev;
    logic [CNT_W-1:0] cnt_q;
    logic [PKT_W-1:0] shreg_q;
    logic             side_q;
    logic             pkt_valid_q;
    logic [PKT_W-1:0] pkt_data_q;
    logic             pkt_side_q;

    logic sck_rise;
    logic ws_chg;
    logic collecting;

    assign sck_rise   = sck_s & ~sck_d;
    assign ws_chg     = sck_rise & (ws_s ^ ws_prev);
    assign collecting = (state_q == ST_RECV) || (state_q == ST_FINISH);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (!enable)     state_d = ST_IDLE;
                else if (ws_chg) state_d = ST_RECV;
            end
            ST_RECV: begin
                if (!enable && ws_chg) state_d = ST_IDLE;
                else if (!enable)      state_d = ST_FINISH;
            end
            ST_FINISH: begin
                if (ws_chg)      state_d = enable ? ST_RECV : ST_IDLE;
                else if (enable) state_d = ST_RECV;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Edge tracking and deserialiser (output process)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d       <= 1'b0;
            ws_prev     <= 1'b0;
            cnt_q       <= '0;
            shreg_q     <= '0;
            side_q      <= 1'b0;
            pkt_valid_q <= 1'b0;
            pkt_data_q  <= '0;
            pkt_side_q  <= 1'b0;
        end else begin
            sck_d       <= sck_s;
            pkt_valid_q <= 1'b0;
            if (sck_rise) begin
                ws_prev <= ws_s;
            end
            if (!collecting) begin
                cnt_q <= '0;
            end else if (sck_rise) begin
                shreg_q <= {shreg_q[PKT_W-2:0], sd_s};
                if (cnt_q == '0 && !ws_chg) begin
                    side_q <= ws_s;
                end
                if (cnt_q == LAST) begin
                    pkt_valid_q <= 1'b1;
                    pkt_data_q  <= {shreg_q[PKT_W-2:0], sd_s};
                    pkt_side_q  <= side_q;
                end
                if (ws_chg || cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign pkt_valid = pkt_valid_q;
    assign pkt_data  = pkt_data_q;
    assign pkt_side  = pkt_side_q;

    // R1
    pkt_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_q |-> $past(sck_rise));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_IDLE) |-> !pkt_valid_q);

    // R8
    align_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ALIGN) |-> !pkt_valid_q);

endmodule

// File: rtl/i2s_rx_regs.sv
module i2s_rx_regs
    import i2s_rx_pkg::*;
#(
    parameter int PKT_W = PKT_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [PKT_W-1:0] pkt_data,
    input  logic             pkt_side,
    input  logic             rd_data,
    input  logic             rd_stat,
    input  logic             full_ie,
    input  logic             err_ie,
    output logic [PKT_W-1:0] rx_data,
    output logic             rx_side,
    output logic             rx_full,
    output logic             rx_ovr,
    output logic             irq
);

    logic [PKT_W-1:0] data_q;
    logic             side_q;
    logic             full_q;
    logic             ovr_q;
    logic             seen_q;
    logic             load;
    logic             lost;

    assign load = pkt_valid & (~full_q | rd_data);
    assign lost = pkt_valid & full_q & ~rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            side_q <= 1'b0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            if (load) begin
                data_q <= pkt_data;
                side_q <= pkt_side;
                full_q <= 1'b1;
            end else if (rd_data) begin
                full_q <= 1'b0;
            end
            if (lost) begin
                ovr_q  <= 1'b1;
                seen_q <= 1'b0;
            end else if (ovr_q) begin
                if (rd_stat && seen_q) begin
                    ovr_q  <= 1'b0;
                    seen_q <= 1'b0;
                end else if (rd_data) begin
                    seen_q <= 1'b1;
                end
            end
        end
    end

    assign rx_data = data_q;
    assign rx_side = side_q;
    assign rx_full = full_q;
    assign rx_ovr  = ovr_q;
    assign irq     = (full_q & full_ie) | (ovr_q & err_ie);

    // R5
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && full_q && !rd_data) |=> ovr_q);

    // R5
    keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && full_q && !rd_data) |=> $stable(data_q));

    // R3
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !pkt_valid) |=> !full_q);

    // R6
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !rd_stat) |=> ovr_q);

    // R4
    side_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !full_q) |=> (side_q == $past(pkt_side)));

endmodule

// File: rtl/i2s_rx_slave.sv
module i2s_rx_slave
    import i2s_rx_pkg::*;
#(
    parameter int PKT_W  = PKT_BITS,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             full_ie,
    input  logic             err_ie,
    input  logic             rd_data,
    input  logic             rd_stat,
    input  logic             sck,
    input  logic             ws,
    input  logic             sd,
    output logic [PKT_W-1:0] rx_data,
    output logic             rx_side,
    output logic             rx_full,
    output logic             rx_ovr,
    output logic             irq
);

    logic [2:0]       pins_s;
    logic             pkt_valid;
    logic [PKT_W-1:0] pkt_data;
    logic             pkt_side;

    i2s_rx_sync #(
        .WIDTH  (3),
        .STAGES (STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sck, ws, sd}),
        .sync_out (pins_s)
    );

    i2s_rx_frame #(
        .PKT_W (PKT_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sck_s     (pins_s[2]),
        .ws_s      (pins_s[1]),
        .sd_s      (pins_s[0]),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data),
        .pkt_side  (pkt_side)
    );

    i2s_rx_regs #(
        .PKT_W (PKT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data),
        .pkt_side  (pkt_side),
        .rd_data   (rd_data),
        .rd_stat   (rd_stat),
        .full_ie   (full_ie),
        .err_ie    (err_ie),
        .rx_data   (rx_data),
        .rx_side   (rx_side),
        .rx_full   (rx_full),
        .rx_ovr    (rx_ovr),
        .irq       (irq)
    );

endmodule

// File: tb/i2s_rx_slave_tb.sv
module i2s_rx_slave_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        full_ie = 1'b0;
    logic        err_ie = 1'b0;
    logic        rd_data = 1'b0;
    logic        rd_stat = 1'b0;
    logic        sck = 1'b0;
    logic        ws = 1'b1;
    logic        sd = 1'b0;
    logic [15:0] rx_data;
    logic        rx_side;
    logic        rx_full;
    logic        rx_ovr;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    i2s_rx_slave u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .full_ie (full_ie),
        .err_ie  (err_ie),
        .rd_data (rd_data),
        .rd_stat (rd_stat),
        .sck     (sck),
        .ws      (ws),
        .sd      (sd),
        .rx_data (rx_data),
        .rx_side (rx_side),
        .rx_full (rx_full),
        .rx_ovr  (rx_ovr),
        .irq     (irq)
    );

    // {side, is_32bit, word}; sides alternate as on a real link
    localparam int NVEC = 6;
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 32'h0000_A5C3},
        {1'b1, 1'b0, 32'h0000_8001},
        {1'b0, 1'b1, 32'h1234_ABCD},
        {1'b1, 1'b1, 32'hFFFF_0000},
        {1'b0, 1'b0, 32'h0000_0000},
        {1'b1, 1'b0, 32'h0000_7FFE}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tx_bit(input logic b, input logic w);
        sck = 1'b0;
        sd  = b;
        ws  = w;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_half(input logic side, input logic [15:0] d, input bit flip_last);
        for (int b = 15; b >= 0; b--) begin
            tx_bit(d[b], (b == 0 && flip_last) ? ~side : side);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read();
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_stat();
        rd_stat = 1'b1;
        @(negedge clk);
        rd_stat = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_pkt(input logic [15:0] d, input logic side, input string tag);
        chk(rx_full == 1'b1, {tag, " full"}, 32'(rx_full), 32'd1);
        chk(rx_data == d, {tag, " data"}, 32'(rx_data), 32'(d));
        chk(rx_side == side, {tag, " side"}, 32'(rx_side), 32'(side));
        do_read();
        chk(rx_full == 1'b0, "R3 cleared by read", 32'(rx_full), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(rx_full == 1'b0 && rx_ovr == 1'b0 && irq == 1'b0, "R11 flags", {29'd0, rx_full, rx_ovr, irq}, 32'd0);
        chk(rx_data == 16'h0, "R11 data", 32'(rx_data), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 idle: bit clock toggling with enable low
        send_half(1'b1, 16'hFFFF, 1'b0);
        chk(rx_full == 1'b0, "R10 idle no packet", 32'(rx_full), 32'd0);

        // R8 enable mid-word: this word is discarded
        enable = 1'b1;
        repeat (2) @(negedge clk);
        send_half(1'b1, 16'h5A5A, 1'b1);
        chk(rx_full == 1'b0, "R8 partial word dropped", 32'(rx_full), 32'd0);

        // Table walk: R1 data order, R2 wide slots, R4 side tags
        for (int i = 0; i < NVEC; i++) begin
            logic        side;
            logic        wide;
            logic [31:0] word;
            side = VEC[i][33];
            wide = VEC[i][32];
            word = VEC[i][31:0];
            if (wide) begin
                send_half(side, word[31:16], 1'b0);
                expect_pkt(word[31:16], side, "R2 upper half");
                send_half(side, word[15:0], 1'b1);
                expect_pkt(word[15:0], side, "R2 lower half");
            end else begin
                send_half(side, word[15:0], 1'b1);
                expect_pkt(word[15:0], side, "R1 R4 packet");
            end
        end

        // R7 and R5: overrun with interrupt enables
        send_half(1'b0, 16'h1111, 1'b1);
        chk(irq == 1'b0, "R7 irq masked", 32'(irq), 32'd0);
        full_ie = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R7 irq on full", 32'(irq), 32'd1);
        full_ie = 1'b0;
        send_half(1'b1, 16'h2222, 1'b1);
        chk(rx_ovr == 1'b1, "R5 overrun set", 32'(rx_ovr), 32'd1);
        chk(rx_data == 16'h1111, "R5 old packet kept", 32'(rx_data), 32'h1111);
        chk(rx_side == 1'b0, "R5 old side kept", 32'(rx_side), 32'd0);
        chk(irq == 1'b0, "R7 error masked", 32'(irq), 32'd0);
        err_ie = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R7 irq on overrun", 32'(irq), 32'd1);

        // R6 clear sequence
        do_stat();
        chk(rx_ovr == 1'b1, "R6 status alone keeps overrun", 32'(rx_ovr), 32'd1);
        do_read();
        chk(rx_ovr == 1'b1, "R6 data read alone keeps overrun", 32'(rx_ovr), 32'd1);
        do_stat();
        chk(rx_ovr == 1'b0, "R6 cleared by data then status", 32'(rx_ovr), 32'd0);
        chk(irq == 1'b0, "R7 irq drops", 32'(irq), 32'd0);
        err_ie = 1'b0;

        // R9 disable mid-word: finish the 32-bit slot, ignore the next word
        for (int b = 15; b >= 8; b--) begin
            logic [15:0] hi;
            hi = 16'hC3A5;
            tx_bit(hi[b], 1'b0);
        end
        enable = 1'b0;
        for (int b = 7; b >= 0; b--) begin
            logic [15:0] hi;
            hi = 16'hC3A5;
            tx_bit(hi[b], 1'b0);
        end
        repeat (2) @(negedge clk);
        expect_pkt(16'hC3A5, 1'b0, "R9 first packet after disable");
        send_half(1'b0, 16'h0F0F, 1'b1);
        expect_pkt(16'h0F0F, 1'b0, "R9 word completed");
        send_half(1'b1, 16'hBEEF, 1'b1);
        chk(rx_full == 1'b0, "R9 next word not received", 32'(rx_full), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule